// File: doc/BRIEF.md
# Staggered Three-Path Field Capture and Readout Controller

This controller sits between several free-running, unlocked cameras and a single output stream of video fields. A video switch matrix in front of it routes a camera to each of three capture paths, and each path owns a FIFO that holds exactly one field. The cameras are not locked to each other, so a field start can arrive on any path at any time. The controller waits on each path for the start of an odd-parity field and opens that path's FIFO for writing. It closes the write when the field ends. It then reads the paths out one field at a time in a fixed rotation, so that the output carries fields back to back.

Each path moves through four states: idle, armed (waiting for an odd field start), writing, and holding a full field. A path leaves the armed state only on an odd-parity field start. It may be read while it is writing, because the FIFO lets reads trail writes, or while it holds a full field. Once its field has been both written and read out, it re-arms and asks the matrix for the next camera. Reading begins when path 0 captures its first field. After that, each pulse of the next-field request moves the read to the next path. If the rotation lands on a path that has no field, the controller flags an underrun for one clock.

Top module: `fieldmux_ctrl`

## Requirements
- R1: While reset is asserted, wr_en, rd_en, sw_req and underrun are all low. On the first clock edge after reset is released, every path arms, so sw_req reads all ones for exactly one cycle.
- R2: In the armed state, a field start with the parity bit low (even field) is ignored. The path stays armed and wr_en stays low.
- R3: In the armed state, a field start with the parity bit high (odd field) raises that path's wr_en from the next cycle. wr_en stays high up to and including the cycle of that path's field-done strobe, and is low from the cycle after.
- R4: A field-done strobe on a path that is not writing has no effect. A field start on a path that is not armed also has no effect.
- R5: Reading starts in the cycle after path 0 first captures an odd field start. From then on, rd_en is high for the selected path whenever that path is writing or holds a full field.
- R6: Reads rotate through the paths in the order 0, 1, 2, 0. Each next-field request (nxt_req high for one cycle) selects the next path from the following cycle. A request made before reading has started is ignored. At most one bit of rd_en is high.
- R7: In the cycle after the rotation moves to a path that is neither writing nor holding a full field, underrun is high. rd_en stays low for that path.
- R8: A path that holds a full field re-arms when a next-field request ends its read. sw_req for that path is then high for exactly one cycle, the cycle after the request.
- R9: If a path's read ends while that path is still writing, the write continues until its field-done strobe. The path then re-arms directly, without holding a full field, and pulses sw_req in the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_stb | input | NPATH | Per-path field-start strobe |
| fs_odd | input | NPATH | Per-path field parity, high for odd, valid with fs_stb |
| fd_stb | input | NPATH | Per-path strobe: the last word of the field has been written |
| nxt_req | input | 1 | Next-field request: the current output field has been read out |
| wr_en | output | NPATH | Per-path FIFO write enable |
| rd_en | output | NPATH | Per-path FIFO read enable |
| sw_req | output | NPATH | Per-path one-cycle request to switch the matrix to the next camera |
| underrun | output | 1 | One-cycle flag: the rotation reached a path with no field |

## Verification
All results are registered, and each is due exactly one clock after the edge that samples its stimulus:
- wr_en and sw_req follow a field start or a field-done strobe.
- rd_en follows a next-field request.
- underrun follows a move of the rotation.

The bench changes inputs only on falling edges and holds each strobe across exactly one rising edge. It compares every output against a behavioural model at the next falling edge, which is the first point where the new value is settled. Directed checks are placed in that same cycle, and the following cycle confirms that each pulse is only one clock wide.

// File: rtl/fieldmux_ctrl.sv
module fieldmux_ctrl #(
  parameter int NPATH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPATH-1:0] fs_stb,
  input  logic [NPATH-1:0] fs_odd,
  input  logic [NPATH-1:0] fd_stb,
  input  logic             nxt_req,
  output logic [NPATH-1:0] wr_en,
  output logic [NPATH-1:0] rd_en,
  output logic [NPATH-1:0] sw_req,
  output logic             underrun
);
  localparam int PW = (NPATH > 1) ? $clog2(NPATH) : 1;
  localparam logic [PW-1:0] LAST = PW'(NPATH - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_ARM = 2'd1, S_WR = 2'd2, S_FULL = 2'd3;

  logic [PW-1:0]    ptr;
  logic             rd_on, arrived;
  logic [NPATH-1:0] has_fld;
  logic [NPATH-1:0] sel_vec;
  logic             first_cap;

  wire advance = nxt_req & rd_on;

  genvar p;
  generate
    for (p = 0; p < NPATH; p++) begin : g_path
      logic [1:0] st, nst;
      logic       drn, ndrn, sw;
      wire        sel = advance && (ptr == PW'(p));

      always_comb begin
        nst  = st;
        ndrn = drn;
        case (st)
          S_IDLE: nst = S_ARM;
          S_ARM:  if (fs_stb[p] && fs_odd[p]) nst = S_WR;
          S_WR: begin
            if (fd_stb[p]) begin
              nst  = (drn || sel) ? S_ARM : S_FULL;
              ndrn = 1'b0;
            end else if (sel) begin
              ndrn = 1'b1;
            end
          end
          default: if (sel) nst = S_ARM;
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st  <= S_IDLE;
          drn <= 1'b0;
          sw  <= 1'b0;
        end else begin
          st  <= nst;
          drn <= ndrn;
          sw  <= (nst == S_ARM) && (st != S_ARM);
        end
      end

      assign wr_en[p]   = (st == S_WR);
      assign has_fld[p] = st[1];
      assign sel_vec[p] = (ptr == PW'(p));
      assign rd_en[p]   = rd_on && sel_vec[p] && has_fld[p];
      assign sw_req[p]  = sw;

      // R2
      even_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ARM && fs_stb[p] && !fs_odd[p]) |=> !wr_en[p]);
      // R3
      odd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ARM && fs_stb[p] && fs_odd[p]) |=> wr_en[p]);
      // R3
      wr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[p] && fd_stb[p]) |=> !wr_en[p]);
      // R8
      sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req[p] |=> !sw_req[p]);
      // R8
      sw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req[p] |-> (!wr_en[p] && !rd_en[p]));
    end
  endgenerate

  assign first_cap = (g_path[0].st == S_ARM) && fs_stb[0] && fs_odd[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      rd_on   <= 1'b0;
      arrived <= 1'b0;
    end else begin
      if (first_cap) rd_on <= 1'b1;
      arrived <= advance;
      if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  assign underrun = arrived && ((sel_vec & has_fld) == '0);

  // R6
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en));
  // R6
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ptr == LAST) |=> (ptr == '0));
  // R7
  underrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (rd_en == '0));
  // R5
  rd_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_on |-> (rd_en == '0 && !underrun));
endmodule

// File: tb/fieldmux_ctrl_test.sv
module fieldmux_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic [2:0] fs_stb = 0, fs_odd = 0, fd_stb = 0;
  logic       nxt_req = 0;
  logic [2:0] wr_en, rd_en, sw_req;
  logic       underrun;
  int ncmp = 0, nbad = 0;
  bit finished = 0;

  fieldmux_ctrl #(.NPATH(3)) uut (.*);

  always #4 clk = ~clk;

  // behavioural model: 0 idle, 1 armed, 2 writing, 3 full
  int ms[3], md[3], mc[3];
  int mon = 0, mptr = 0, marr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin ms[i] = 0; md[i] = 0; mc[i] = 0; end
      mon = 0; mptr = 0; marr = 0;
    end else begin
      int adv, nw;
      adv = nxt_req && mon;
      if (ms[0] == 1 && fs_stb[0] && fs_odd[0]) mon = 1;
      for (int i = 0; i < 3; i++) begin
        int hit;
        hit = adv && (mptr == i);
        nw = ms[i];
        if (ms[i] == 0) nw = 1;
        else if (ms[i] == 1) begin
          if (fs_stb[i] && fs_odd[i]) nw = 2;
        end else if (ms[i] == 2) begin
          if (fd_stb[i]) begin
            nw = (md[i] || hit) ? 1 : 3;
            md[i] = 0;
          end else if (hit) md[i] = 1;
        end else if (hit) nw = 1;
        mc[i] = (nw == 1 && ms[i] != 1);
        ms[i] = nw;
      end
      marr = adv;
      if (adv) mptr = (mptr + 1) % 3;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [2:0] ew, er, es;
    logic eu;
    for (int i = 0; i < 3; i++) begin
      ew[i] = (ms[i] == 2);
      er[i] = mon && (mptr == i) && (ms[i] >= 2);
      es[i] = mc[i][0];
    end
    eu = marr && (ms[mptr] < 2);
    chk(wr_en == ew, "R3 wr_en model", wr_en, ew);
    chk(rd_en == er, "R6 rd_en model", rd_en, er);
    chk(sw_req == es, "R8 sw_req model", sw_req, es);
    chk(underrun == eu, "R7 underrun model", underrun, eu);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    fs_stb = 0; fs_odd = 0; fd_stb = 0; nxt_req = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all();
    chk({wr_en, rd_en, sw_req, underrun} == 0, "R1 reset outputs", {wr_en, rd_en, sw_req, underrun}, 0);
    rst_n = 1;
    tick();
    chk(sw_req == 3'b111, "R1 arm after reset", sw_req, 7);
    tick();
    chk(sw_req == 3'b000, "R8 switch pulse width", sw_req, 0);
    fs_stb = 3'b001;
    tick();
    chk(wr_en == 3'b000, "R2 even field ignored", wr_en, 0);
    nxt_req = 1;
    tick();
    chk(rd_en == 3'b000 && !underrun, "R6 request before start ignored", rd_en, 0);
    fs_stb = 3'b001; fs_odd = 3'b001; fd_stb = 3'b010;
    tick();
    chk(wr_en == 3'b001, "R3 odd start / R4 stray done", wr_en, 1);
    chk(rd_en == 3'b001, "R5 read starts on path 0", rd_en, 1);
    repeat (3) tick();
    fs_stb = 3'b010; fs_odd = 3'b010;
    tick();
    chk(wr_en == 3'b011, "R3 path 1 start", wr_en, 3);
    fd_stb = 3'b001;
    tick();
    chk(wr_en == 3'b010, "R3 write ends after done", wr_en, 2);
    chk(rd_en == 3'b001, "R5 full path still read", rd_en, 1);
    fs_stb = 3'b101; fs_odd = 3'b101;
    tick();
    chk(wr_en == 3'b110, "R4 start on full path ignored", wr_en, 6);
    nxt_req = 1;
    tick();
    chk(rd_en == 3'b010, "R6 rotate to path 1", rd_en, 2);
    chk(sw_req == 3'b001, "R8 full path re-arms", sw_req, 1);
    nxt_req = 1;
    tick();
    chk(rd_en == 3'b100, "R6 rotate to path 2", rd_en, 4);
    chk(wr_en == 3'b110, "R9 path 1 keeps writing", wr_en, 6);
    nxt_req = 1;
    tick();
    chk(underrun == 1'b1, "R7 underrun on armed path", underrun, 1);
    chk(rd_en == 3'b000, "R7 no read on empty path", rd_en, 0);
    tick();
    chk(underrun == 1'b0, "R7 underrun one cycle", underrun, 0);
    fd_stb = 3'b010;
    tick();
    chk(sw_req == 3'b010, "R9 drained path re-arms on done", sw_req, 2);
    chk(wr_en == 3'b100, "R9 write closed", wr_en, 4);
    fd_stb = 3'b100;
    tick();
    chk(sw_req == 3'b100, "R9 second drained path", sw_req, 4);
    for (int n = 0; n < 6000; n++) begin
      for (int i = 0; i < 3; i++) begin
        fs_stb[i] = ($urandom_range(0, 59) == 0);
        fs_odd[i] = $urandom_range(0, 1);
        fd_stb[i] = ($urandom_range(0, 49) == 0);
      end
      nxt_req = ($urandom_range(0, 39) == 0);
      tick();
    end
    finish_run();
  end
endmodule